// File: doc/BRIEF.md
# Serialised Vector Convoy Timing Sequencer

This block works out the timing of a short programme of vector convoys and plays it back one cycle at a time. Each convoy goes to pipelined functional units that have a fixed start-up latency. Every convoy uses the same vector length. A single start pulse captures the programme:

- up to eight two-bit convoy class codes;
- the index of the final convoy;
- the vector length.

The sequencer then runs the convoys one after another with no overlap and no chaining. Each convoy begins on the cycle after the previous convoy produced its last element.

While a run is active, the block strobes one output per element result, tagged with the convoy number and the element index. On the last cycle of each convoy it pulses a timestamp record that gives the start cycle, the first-result cycle and the last-result cycle. All times count from the start pulse: the cycle that begins at the clock edge sampling `start_i` is cycle 0. A one-cycle done pulse marks the end of the programme. The block is used to model, and to check, convoy schedules for an in-order vector unit. No data moves through it.

Top module: `vconvoy_seq`

## Requirements
- R1: The start-up penalty depends on the convoy class. Class code 0 (memory load/store) costs 12 cycles, code 1 (multiply) costs 7, code 2 (add) costs 6, and code 3 (memory paired with multiply) costs 12, because the slower unit governs. A convoy's first result appears at its start cycle plus this penalty.
- R2: With vector length n ≥ 1, a convoy produces exactly one result per cycle on n consecutive cycles. The element index runs 0 to n−1, and the last result is at start + penalty + n − 1.
- R3: `result_conv_o` names the convoy whose element is strobed. Results appear only while `busy_o` is high.
- R4: A convoy starts on the cycle right after the previous convoy's last result, and convoys never overlap.
- R5: `ts_valid_o` pulses on a convoy's final cycle. At that cycle `ts_conv_o`, `ts_start_o`, `ts_first_o` and `ts_last_o` give that convoy's number and its 16-bit cycle times. The first convoy starts at cycle 0.
- R6: `done_o` is high for exactly one cycle: the cycle after the final convoy's last result. `busy_o` falls on that same cycle.
- R7: The programme runs convoys 0 through `last_conv_i`, so it has between 1 and 8 convoys. Convoy c takes its class from `classes_i[2c+1:2c]`.
- R8: A vector length of 0 gives each convoy a single cycle with no results. Its timestamp record has first = last = start.
- R9: A vector length above 64 is treated as 64.
- R10: A start pulse that arrives while `busy_o` is high has no effect on the running programme.
- R11: After reset, `busy_o`, `done_o`, `result_valid_o` and `ts_valid_o` are low.
- R12: The programme load, memory+multiply, add, store produces its final store result at cycle 41 + 4n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Captures the programme and begins a run (when idle) |
| vlen_i | input | 7 | Vector length n, 0 to 127 (clamped to 64) |
| last_conv_i | input | 3 | Index of the final convoy |
| classes_i | input | 16 | Two-bit class code per convoy, convoy c at bits [2c+1:2c] |
| busy_o | output | 1 | Run in progress |
| result_valid_o | output | 1 | One element result completes this cycle |
| result_conv_o | output | 3 | Convoy of the strobed result |
| result_elem_o | output | 6 | Element index of the strobed result |
| ts_valid_o | output | 1 | Timestamp record valid (last cycle of a convoy) |
| ts_conv_o | output | 3 | Convoy of the timestamp record |
| ts_start_o | output | 16 | Start cycle of the convoy |
| ts_first_o | output | 16 | First-result cycle of the convoy |
| ts_last_o | output | 16 | Last-result cycle of the convoy |
| done_o | output | 1 | One-cycle pulse after the final convoy |

## Verification
A wrong class-to-penalty mapping or a bad per-convoy phase counter moves the result strobe window of that convoy right away. Every later timestamp then shifts as well, because start times accumulate. A stale convoy index or a bad start-time register shows up at the next timestamp pulse, as a wrong `ts_conv_o` or a `ts_start_o` that is not the previous last plus one. Faulty end-of-programme logic shows up within one cycle of the final result, as a missing, repeated or misplaced `done_o` pulse. A busy guard that fails to protect the captured length or classes stretches or shortens every convoy that follows the stray start pulse.

// File: rtl/vcs_pkg.sv
package vcs_pkg;
  typedef enum logic [1:0] {
    CLS_MEM    = 2'd0,
    CLS_MUL    = 2'd1,
    CLS_ADD    = 2'd2,
    CLS_MEMMUL = 2'd3
  } vclass_e;
endpackage

// File: rtl/vcs_penalty.sv
module vcs_penalty
  import vcs_pkg::*;
#(
  parameter int PW      = 5,
  parameter int MEM_PEN = 12,
  parameter int MUL_PEN = 7,
  parameter int ADD_PEN = 6
) (
  input  vclass_e         cls_i,
  output logic [PW-1:0]   pen_o
);
  // paired units: slower one sets the start-up
  localparam int COMBO_PEN = (MEM_PEN > MUL_PEN) ? MEM_PEN : MUL_PEN;

  always_comb begin
    unique case (cls_i)
      CLS_MEM:    pen_o = PW'(MEM_PEN);
      CLS_MUL:    pen_o = PW'(MUL_PEN);
      CLS_ADD:    pen_o = PW'(ADD_PEN);
      default:    pen_o = PW'(COMBO_PEN);
    endcase
  end
endmodule

// File: rtl/vcs_desc_store.sv
module vcs_desc_store
  import vcs_pkg::*;
#(
  parameter int NCONV = 8,
  parameter int IW    = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [2*NCONV-1:0] cls_i,
  input  logic [IW-1:0]      sel_i,
  output vclass_e            cls_o
);
  logic [1:0] slot_q [NCONV];

  for (genvar g = 0; g < NCONV; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     slot_q[g] <= 2'd0;
      else if (load_i) slot_q[g] <= cls_i[2*g +: 2];
    end
  end

  assign cls_o = vclass_e'(slot_q[sel_i]);
endmodule

// File: rtl/vcs_convoy_timer.sv
module vcs_convoy_timer #(
  parameter int PW = 5,
  parameter int LW = 7,
  parameter int EW = 6,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          run_i,
  input  logic [PW-1:0] pen_i,
  input  logic [LW-1:0] n_i,
  output logic          res_valid_o,
  output logic [EW-1:0] res_elem_o,
  output logic          last_o
);
  logic [CW-1:0] phase_q;
  logic [CW-1:0] pen_w, end_w;

  assign pen_w = CW'(pen_i);
  assign end_w = pen_w + CW'(n_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          phase_q <= '0;
    else if (go_i)                        phase_q <= '0;
    else if (run_i && phase_q != '1)      phase_q <= phase_q + 1'b1;
  end

  assign res_valid_o = run_i && (phase_q >= pen_w) && (phase_q < end_w);
  assign res_elem_o  = EW'(phase_q - pen_w);
  // zero length: convoy occupies its start cycle only
  assign last_o      = run_i && ((n_i == '0) ? (phase_q == '0) : (phase_q == end_w - 1'b1));

  AST_ELEM_CONTIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !last_o) |=> res_valid_o);  // R2
  AST_ELEM_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !last_o) |=> (res_elem_o == $past(res_elem_o) + 1'b1));  // R2
endmodule

// File: rtl/vconvoy_seq.sv
module vconvoy_seq
  import vcs_pkg::*;
#(
  parameter int NCONV   = 8,
  parameter int MAX_VL  = 64,
  parameter int TSW     = 16,
  parameter int MEM_PEN = 12,
  parameter int MUL_PEN = 7,
  parameter int ADD_PEN = 6,
  localparam int IW     = $clog2(NCONV),
  localparam int LW     = $clog2(MAX_VL + 1),
  localparam int EW     = $clog2(MAX_VL),
  localparam int PW     = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [LW-1:0]      vlen_i,
  input  logic [IW-1:0]      last_conv_i,
  input  logic [2*NCONV-1:0] classes_i,
  output logic               busy_o,
  output logic               result_valid_o,
  output logic [IW-1:0]      result_conv_o,
  output logic [EW-1:0]      result_elem_o,
  output logic               ts_valid_o,
  output logic [IW-1:0]      ts_conv_o,
  output logic [TSW-1:0]     ts_start_o,
  output logic [TSW-1:0]     ts_first_o,
  output logic [TSW-1:0]     ts_last_o,
  output logic               done_o
);
  localparam int            CW   = PW + LW + 1;
  localparam logic [LW-1:0] MAXV = LW'(MAX_VL);

  logic           busy_q, done_q;
  logic [TSW-1:0] cyc_q, cstart_q;
  logic [IW-1:0]  idx_q, lastc_q;
  logic [LW-1:0]  n_q;
  logic           accept, conv_last, final_conv, go;
  vclass_e        cur_cls;
  logic [PW-1:0]  cur_pen;

  assign accept     = start_i && !busy_q;
  assign final_conv = (idx_q == lastc_q);
  assign go         = accept || (busy_q && conv_last && !final_conv);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      cyc_q    <= '0;
      cstart_q <= '0;
      idx_q    <= '0;
      lastc_q  <= '0;
      n_q      <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q   <= 1'b1;
        cyc_q    <= '0;
        cstart_q <= '0;
        idx_q    <= '0;
        lastc_q  <= last_conv_i;
        n_q      <= (vlen_i > MAXV) ? MAXV : vlen_i;
      end else if (busy_q) begin
        cyc_q <= cyc_q + 1'b1;
        if (conv_last) begin
          if (final_conv) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            idx_q    <= idx_q + 1'b1;
            cstart_q <= cyc_q + 1'b1;
          end
        end
      end
    end
  end

  vcs_desc_store #(.NCONV(NCONV), .IW(IW)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .cls_i  (classes_i),
    .sel_i  (idx_q),
    .cls_o  (cur_cls)
  );

  vcs_penalty #(.PW(PW), .MEM_PEN(MEM_PEN), .MUL_PEN(MUL_PEN), .ADD_PEN(ADD_PEN)) u_pen (
    .cls_i (cur_cls),
    .pen_o (cur_pen)
  );

  vcs_convoy_timer #(.PW(PW), .LW(LW), .EW(EW), .CW(CW)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go),
    .run_i       (busy_q),
    .pen_i       (cur_pen),
    .n_i         (n_q),
    .res_valid_o (result_valid_o),
    .res_elem_o  (result_elem_o),
    .last_o      (conv_last)
  );

  assign busy_o        = busy_q;
  assign done_o        = done_q;
  assign result_conv_o = idx_q;
  assign ts_valid_o    = busy_q && conv_last;
  assign ts_conv_o     = idx_q;
  assign ts_start_o    = cstart_q;
  assign ts_first_o    = (n_q == '0) ? cstart_q : cstart_q + TSW'(cur_pen);
  assign ts_last_o     = (n_q == '0) ? cstart_q
                                     : cstart_q + TSW'(cur_pen) + TSW'(n_q) - 1'b1;

  AST_RESULT_IN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> busy_o);  // R3
  AST_NEXT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_valid_o |=> (!busy_o || ts_start_o == $past(ts_last_o) + 1'b1));  // R4
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R6
  AST_DONE_AFTER_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $fell(busy_o));  // R6
  AST_BUSY_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> ($stable(n_q) && $stable(lastc_q)));  // R10
  AST_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (idx_q <= lastc_q));  // R7
endmodule

// File: tb/vconvoy_seq_tb.sv
module vconvoy_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [6:0]  vlen_i = '0;
  logic [2:0]  last_conv_i = '0;
  logic [15:0] classes_i = '0;
  logic        busy_o, result_valid_o, ts_valid_o, done_o;
  logic [2:0]  result_conv_o, ts_conv_o;
  logic [5:0]  result_elem_o;
  logic [15:0] ts_start_o, ts_first_o, ts_last_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  vconvoy_seq u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .vlen_i(vlen_i),
    .last_conv_i(last_conv_i), .classes_i(classes_i), .busy_o(busy_o),
    .result_valid_o(result_valid_o), .result_conv_o(result_conv_o),
    .result_elem_o(result_elem_o), .ts_valid_o(ts_valid_o), .ts_conv_o(ts_conv_o),
    .ts_start_o(ts_start_o), .ts_first_o(ts_first_o), .ts_last_o(ts_last_o),
    .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int pen_of(input logic [1:0] c);
    case (c)
      2'd0: return 12;
      2'd1: return 7;
      2'd2: return 6;
      default: return 12;
    endcase
  endfunction

  // runs a programme; optional stray start at window stray_t; returns final last cycle
  task automatic run_prog(input int nconv, input logic [15:0] cls, input int vlen,
                          input int stray_t, output int final_last);
    int st[8], fi[8], la[8];
    int n, t_end, cur;
    n = (vlen > 64) ? 64 : vlen;
    cur = 0;
    for (int c = 0; c < nconv; c++) begin
      st[c] = cur;
      if (n == 0) begin
        fi[c] = cur; la[c] = cur;
      end else begin
        fi[c] = cur + pen_of(cls[2*c +: 2]);
        la[c] = fi[c] + n - 1;
      end
      cur = la[c] + 1;
    end
    t_end = la[nconv-1];
    final_last = t_end;
    @(negedge clk_i);
    start_i = 1'b1; vlen_i = 7'(vlen); last_conv_i = 3'(nconv - 1); classes_i = cls;
    for (int t = 0; t <= t_end + 2; t++) begin
      bit erv, ets, edone, ebusy;
      int ec, ee, tc;
      @(negedge clk_i);
      start_i = 1'b0;
      if (t == stray_t) begin
        start_i = 1'b1; vlen_i = 7'd3; last_conv_i = 3'd0; classes_i = 16'hffff;
      end
      erv = 1'b0; ets = 1'b0; ec = 0; ee = 0; tc = 0;
      for (int c = 0; c < nconv; c++) begin
        if (n > 0 && t >= fi[c] && t <= la[c]) begin
          erv = 1'b1; ec = c; ee = t - fi[c];
        end
        if (t == la[c]) begin
          ets = 1'b1; tc = c;
        end
      end
      edone = (t == t_end + 1);
      ebusy = (t <= t_end);
      chk(result_valid_o == erv, "R2/R8 result_valid", int'(result_valid_o), int'(erv));
      if (erv && result_valid_o) begin
        chk(int'(result_conv_o) == ec, "R3 result_conv", int'(result_conv_o), ec);
        chk(int'(result_elem_o) == ee, "R2 result_elem", int'(result_elem_o), ee);
      end
      chk(ts_valid_o == ets, "R5 ts_valid", int'(ts_valid_o), int'(ets));
      if (ets && ts_valid_o) begin
        chk(int'(ts_conv_o) == tc, "R5 ts_conv", int'(ts_conv_o), tc);
        chk(int'(ts_start_o) == st[tc], "R4 ts_start", int'(ts_start_o), st[tc]);
        chk(int'(ts_first_o) == fi[tc], "R1 ts_first", int'(ts_first_o), fi[tc]);
        chk(int'(ts_last_o) == la[tc], "R2 ts_last", int'(ts_last_o), la[tc]);
      end
      chk(done_o == edone, "R6 done", int'(done_o), int'(edone));
      chk(busy_o == ebusy, "R6 busy", int'(busy_o), int'(ebusy));
    end
    start_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  // classic four-convoy programme: mem, mem+mul, add, mem
  task automatic t_classic(input int n);
    int fl;
    run_prog(4, {8'h00, 2'd0, 2'd2, 2'd3, 2'd0}, n, -1, fl);
    chk(fl == 41 + 4*n, "R12 final store cycle", fl, 41 + 4*n);
  endtask

  task automatic t_mixed_stray;
    int fl;
    // R7 R10: eight convoys, stray start mid-run must be ignored
    run_prog(8, {2'd1, 2'd2, 2'd0, 2'd3, 2'd2, 2'd1, 2'd0, 2'd2}, 5, 20, fl);
  endtask

  task automatic t_zero_len;
    int fl;
    run_prog(3, {10'd0, 2'd2, 2'd1, 2'd0}, 0, -1, fl);  // R8
    chk(fl == 2, "R8 zero length end", fl, 2);
  endtask

  task automatic t_clamp;
    int fl;
    run_prog(1, 16'h0001, 100, -1, fl);  // R9: one multiply, length clamped to 64
    chk(fl == 7 + 63, "R9 clamped last", fl, 70);
  endtask

  task automatic t_reset;
    chk(!busy_o, "R11 busy after reset", int'(busy_o), 0);
    chk(!done_o, "R11 done after reset", int'(done_o), 0);
    chk(!result_valid_o, "R11 result_valid after reset", int'(result_valid_o), 0);
    chk(!ts_valid_o, "R11 ts_valid after reset", int'(ts_valid_o), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_classic(64);
    t_classic(1);
    t_mixed_stray();
    t_zero_len();
    t_clamp();
    t_classic(7);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule